// File: doc/BRIEF.md
# I2C Masked Slave Address Matcher

This block listens to an I2C bus one bit at a time. A bit-valid strobe marks each sampled SDA bit. The block decides whether the address phase that follows a start or repeated start selects this device. The comparison is masked: an address bit takes part only where its mask bit is 1. An all-zero mask therefore makes the block answer every address, whether or not any other device would respond.

A mode input picks the address format.

- In 7-bit mode the first byte carries A6..A0 and then the R/W bit.
- In 10-bit mode a header byte `11110 A9 A8 R/W` comes first. The low byte A7..A0 follows it.
- Within one transfer, after a 10-bit write has selected the block, a repeated start with a read header re-selects it. The low byte is not sent again.

On a match the block raises `addressed` and requests an ACK for the ninth bit period. It also captures the address that actually arrived, together with its length and R/W direction.

Top module: `i2c_addr_match`

The controller steps through these states:

- `S_IDLE`: waits for a start.
- `S_FIRST`: receives the first byte. It goes to `S_ADDR_ACK` on a 7-bit match or a 10-bit read re-selection. It goes to `S_HDR_ACK` on a 10-bit write header. It goes to `S_IGNORE` otherwise.
- `S_HDR_ACK`: acknowledges the header, then moves to `S_SECOND` on the ninth bit.
- `S_SECOND`: receives the low byte. It goes to `S_ADDR_ACK` on a match and to `S_IGNORE` otherwise.
- `S_ADDR_ACK`: acknowledges the address, then moves to `S_TALK` on the ninth bit.
- `S_TALK` and `S_IGNORE`: wait out the rest of the transfer.

From every state, a stop returns to `S_IDLE` and a start goes to `S_FIRST`. A stop takes priority when both arrive together.

## Requirements
- R1: After reset `addressed`, `ack_req`, `rx_addr`, `addr_is_10` and `rw_bit` are all 0.
- R2: In 7-bit mode (`mode10`=0), bits 7..1 of the first byte are compared with `own_addr7` only where `mask7` is 1. On a match, one cycle after the 8th bit strobe, `addressed`=1, `rx_addr`={3'b0, bits 7..1}, `addr_is_10`=0 and `rw_bit`=bit 0.
- R3: With an all-zero mask, every address of the selected format matches and is acknowledged.
- R4: A first byte that does not match leaves `addressed` and `ack_req` at 0. The rest of the transfer is ignored until the next start.
- R5: `ack_req` is 1 from the cycle after the 8th bit strobe of an acknowledged address byte until the cycle after the 9th strobe. It is 0 at all other times.
- R6: In 10-bit mode, a first byte whose bits 7..3 equal 11110, whose bits 2..1 match `own_addr10[9:8]` under `mask10[9:8]`, and whose bit 0 is 0 is acknowledged without setting `addressed`. A following low byte that matches `own_addr10[7:0]` under `mask10[7:0]` sets `addressed`, `rx_addr`={A9..A0}, `addr_is_10`=1 and `rw_bit`=0.
- R7: After a 10-bit write match, a repeated start followed by a matching header with bit 0 = 1 sets `addressed`, `ack_req`, `addr_is_10`=1 and `rw_bit`=1, and `rx_addr` keeps the captured address. A read header with no such earlier write match in the same transfer is ignored.
- R8: A stop clears `addressed` and forgets any 10-bit write selection. A start clears `addressed` and restarts address reception, even in the middle of a byte.
- R9: `mode10` picks the format: 7-bit address bytes are ignored in 10-bit mode, and a byte starting with 11110 is treated as a 7-bit address in 7-bit mode.
- R10: While `addressed` stays 1, `rx_addr`, `addr_is_10` and `rw_bit` do not change, and `addressed` falls only on a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode10 | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| own_addr7 | input | 7 | Own 7-bit address |
| mask7 | input | 7 | 7-bit compare mask, 1 = bit compared |
| own_addr10 | input | 10 | Own 10-bit address |
| mask10 | input | 10 | 10-bit compare mask, 1 = bit compared |
| start_pulse | input | 1 | One-cycle start / repeated start event |
| stop_pulse | input | 1 | One-cycle stop event |
| bit_valid | input | 1 | Strobe: `bit_in` holds a sampled SDA bit |
| bit_in | input | 1 | Sampled SDA value |
| addressed | output | 1 | The block is selected as slave |
| ack_req | output | 1 | Drive ACK during the current ninth bit period |
| rx_addr | output | 10 | Address that matched |
| addr_is_10 | output | 1 | 1 = captured address is 10-bit |
| rw_bit | output | 1 | R/W bit of the selecting byte |

## Verification
The hardest case to reach is the 10-bit read re-selection. It depends on state left behind by an earlier write match in the same transfer, and a stop wipes that state out. The bench sends a complete header and low byte with ACK slots, issues a repeated start with no stop, and sends the read header. It then repeats the same read header after a stop and after a failed low byte to show that the block declines it. Masked 10-bit matches are driven with a mask that frees A9:A8, so the captured address differs from the own address.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR7_W  = 7;
    localparam int ADDR10_W = 10;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FIRST,
        S_HDR_ACK,
        S_SECOND,
        S_ADDR_ACK,
        S_TALK,
        S_IGNORE
    } am_state_e;
endpackage

// File: rtl/am_shift.sv
module am_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              byte_done,
    output logic              ack_slot,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sreg;

    // counts 8 data bits plus the ninth (acknowledge) slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sreg <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (bit_valid) begin
            if (cnt == ACK_BIT) begin
                cnt <= '0;
            end else begin
                sreg <= {sreg[BYTE_W-3:0], bit_in};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    assign byte_val  = {sreg, bit_in};
    assign byte_done = bit_valid && !restart && (cnt == LAST_BIT);
    assign ack_slot  = bit_valid && !restart && (cnt == ACK_BIT);
endmodule

// File: rtl/am_cmp.sv
module am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0]   byte_val,
    input  logic [ADDR7_W-1:0]  own_addr7,
    input  logic [ADDR7_W-1:0]  mask7,
    input  logic [ADDR10_W-1:0] own_addr10,
    input  logic [ADDR10_W-1:0] mask10,
    output logic                hit7,
    output logic                hdr_ok,
    output logic                low_ok,
    output logic                is_read
);
    // masked compare: a cleared mask bit is a don't-care position
    assign hit7    = ((byte_val[BYTE_W-1:1] ^ own_addr7) & mask7) == '0;
    assign hdr_ok  = (byte_val[7:3] == TEN_PREFIX) &&
                     (((byte_val[2:1] ^ own_addr10[9:8]) & mask10[9:8]) == 2'b00);
    assign low_ok  = ((byte_val ^ own_addr10[7:0]) & mask10[7:0]) == '0;
    assign is_read = byte_val[0];
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode10,
    input  logic [ADDR7_W-1:0]  own_addr7,
    input  logic [ADDR7_W-1:0]  mask7,
    input  logic [ADDR10_W-1:0] own_addr10,
    input  logic [ADDR10_W-1:0] mask10,
    input  logic                start_pulse,
    input  logic                stop_pulse,
    input  logic                bit_valid,
    input  logic                bit_in,
    output logic                addressed,
    output logic                ack_req,
    output logic [ADDR10_W-1:0] rx_addr,
    output logic                addr_is_10,
    output logic                rw_bit
);
    localparam int PAD_W = ADDR10_W - ADDR7_W;

    am_state_e state, state_n;
    logic addr_q, addr_n, ten_q, ten_n, len_q, len_n, rw_q, rw_n;
    logic [ADDR10_W-1:0] rx_q, rx_n;
    logic [1:0] hi_q, hi_n;

    logic              byte_done, ack_slot;
    logic [BYTE_W-1:0] byte_val;
    logic              hit7, hdr_ok, low_ok, is_read;

    am_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start_pulse || stop_pulse),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .byte_done (byte_done),
        .ack_slot  (ack_slot),
        .byte_val  (byte_val)
    );

    am_cmp u_cmp (
        .byte_val   (byte_val),
        .own_addr7  (own_addr7),
        .mask7      (mask7),
        .own_addr10 (own_addr10),
        .mask10     (mask10),
        .hit7       (hit7),
        .hdr_ok     (hdr_ok),
        .low_ok     (low_ok),
        .is_read    (is_read)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= 1'b0;
            ten_q  <= 1'b0;
            len_q  <= 1'b0;
            rw_q   <= 1'b0;
            rx_q   <= '0;
            hi_q   <= 2'b00;
        end else begin
            state  <= state_n;
            addr_q <= addr_n;
            ten_q  <= ten_n;
            len_q  <= len_n;
            rw_q   <= rw_n;
            rx_q   <= rx_n;
            hi_q   <= hi_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        addr_n  = addr_q;
        ten_n   = ten_q;
        len_n   = len_q;
        rw_n    = rw_q;
        rx_n    = rx_q;
        hi_n    = hi_q;
        if (stop_pulse) begin
            state_n = S_IDLE;
            addr_n  = 1'b0;
            ten_n   = 1'b0;
        end else if (start_pulse) begin
            state_n = S_FIRST;
            addr_n  = 1'b0;
        end else begin
            unique case (state)
                S_FIRST: if (byte_done) begin
                    if (!mode10) begin
                        if (hit7) begin
                            state_n = S_ADDR_ACK;
                            addr_n  = 1'b1;
                            rx_n    = {{PAD_W{1'b0}}, byte_val[BYTE_W-1:1]};
                            len_n   = 1'b0;
                            rw_n    = is_read;
                        end else begin
                            state_n = S_IGNORE;
                        end
                    end else if (hdr_ok && !is_read) begin
                        state_n = S_HDR_ACK;
                        ten_n   = 1'b0;
                        hi_n    = byte_val[2:1];
                    end else if (hdr_ok && ten_q) begin
                        state_n = S_ADDR_ACK;
                        addr_n  = 1'b1;
                        len_n   = 1'b1;
                        rw_n    = 1'b1;
                    end else begin
                        state_n = S_IGNORE;
                        ten_n   = 1'b0;
                    end
                end
                S_HDR_ACK: if (ack_slot) state_n = S_SECOND;
                S_SECOND: if (byte_done) begin
                    if (low_ok) begin
                        state_n = S_ADDR_ACK;
                        addr_n  = 1'b1;
                        ten_n   = 1'b1;
                        rx_n    = {hi_q, byte_val};
                        len_n   = 1'b1;
                        rw_n    = 1'b0;
                    end else begin
                        state_n = S_IGNORE;
                    end
                end
                S_ADDR_ACK: if (ack_slot) state_n = S_TALK;
                S_IDLE, S_TALK, S_IGNORE: ;
                default: state_n = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ack_req    = (state == S_HDR_ACK) || (state == S_ADDR_ACK);
        addressed  = addr_q;
        rx_addr    = rx_q;
        addr_is_10 = len_q;
        rw_bit     = rw_q;
    end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_pulse,
    input logic       stop_pulse,
    input logic       bit_valid,
    input logic       addressed,
    input logic       ack_req,
    input logic [9:0] rx_addr,
    input logic       addr_is_10,
    input logic       rw_bit
);
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !addressed && !ack_req);

    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !addressed && !ack_req);

    p_ack_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && bit_valid && !start_pulse && !stop_pulse |=> !ack_req);

    p_select_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addressed) |-> ack_req);

    p_hold_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addressed && !start_pulse && !stop_pulse |=> addressed);

    p_hold_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addressed && $past(addressed) |->
            $stable(rx_addr) && $stable(addr_is_10) && $stable(rw_bit));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .bit_valid   (bit_valid),
    .addressed   (addressed),
    .ack_req     (ack_req),
    .rx_addr     (rx_addr),
    .addr_is_10  (addr_is_10),
    .rw_bit      (rw_bit)
);

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode10 = 1'b0;
    logic [6:0] own_addr7 = '0, mask7 = '0;
    logic [9:0] own_addr10 = '0, mask10 = '0;
    logic       start_pulse = 1'b0, stop_pulse = 1'b0;
    logic       bit_valid = 1'b0, bit_in = 1'b0;
    logic       addressed, ack_req, addr_is_10, rw_bit;
    logic [9:0] rx_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_addr_match uut (
        .clk(clk), .rst_n(rst_n), .mode10(mode10),
        .own_addr7(own_addr7), .mask7(mask7),
        .own_addr10(own_addr10), .mask10(mask10),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .addressed(addressed), .ack_req(ack_req), .rx_addr(rx_addr),
        .addr_is_10(addr_is_10), .rw_bit(rw_bit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_bit(input logic b);
        @(negedge clk); bit_in = b; bit_valid = 1'b1;
        @(negedge clk); bit_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) pulse_bit(b[i]);
    endtask

    task automatic do_start();
        @(negedge clk); start_pulse = 1'b1;
        @(negedge clk); start_pulse = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 addressed", addressed, 0);
        chk("R1 ack_req", ack_req, 0);
        chk("R1 rx_addr", rx_addr, 0);
        chk("R1 addr_is_10", addr_is_10, 0);
        chk("R1 rw_bit", rw_bit, 0);
    endtask

    task automatic t_7bit_exact();
        mode10 = 0; own_addr7 = 7'h5A; mask7 = 7'h7F;
        do_start();
        send_byte({7'h5A, 1'b1});
        chk("R5 ack after 8th bit", ack_req, 1);
        chk("R2 addressed", addressed, 1);
        chk("R2 rx_addr", rx_addr, 10'h05A);
        chk("R2 addr_is_10", addr_is_10, 0);
        chk("R2 rw_bit", rw_bit, 1);
        pulse_bit(1'b0);
        chk("R5 ack drops after 9th bit", ack_req, 0);
        send_byte(8'h00);
        chk("R5 no ack on data byte", ack_req, 0);
        pulse_bit(1'b0);
        chk("R10 still addressed", addressed, 1);
        chk("R10 rx_addr held", rx_addr, 10'h05A);
        do_stop();
        chk("R8 stop clears addressed", addressed, 0);
    endtask

    task automatic t_7bit_masked();
        mode10 = 0; own_addr7 = 7'h5A; mask7 = 7'h70;
        do_start();
        send_byte({7'h53, 1'b0});
        chk("R2 masked match", addressed, 1);
        chk("R2 masked rx_addr", rx_addr, 10'h053);
        chk("R2 masked rw_bit", rw_bit, 0);
        pulse_bit(1'b0);
        do_start();
        send_byte({7'h3A, 1'b0});
        chk("R4 mismatch addressed", addressed, 0);
        chk("R4 mismatch ack", ack_req, 0);
        pulse_bit(1'b1);
        send_byte({7'h5A, 1'b0});
        chk("R4 later byte ignored addressed", addressed, 0);
        chk("R4 later byte ignored ack", ack_req, 0);
        do_stop();
    endtask

    task automatic t_promisc();
        mode10 = 0; own_addr7 = 7'h5A; mask7 = 7'h00;
        do_start(); send_byte(8'h00);
        chk("R3 zero mask 0x00 ack", ack_req, 1);
        chk("R3 zero mask 0x00 rx", rx_addr, 10'h000);
        pulse_bit(1'b0);
        do_start(); send_byte(8'hFF);
        chk("R3 zero mask 0x7F ack", ack_req, 1);
        chk("R3 zero mask 0x7F rx", rx_addr, 10'h07F);
        pulse_bit(1'b0);
        do_start(); send_byte(8'h22);
        chk("R3 zero mask 0x11 rx", rx_addr, 10'h011);
        pulse_bit(1'b0);
        do_stop();
    endtask

    task automatic t_10bit_write_read();
        mode10 = 1; own_addr10 = 10'h2C5; mask10 = 10'h3FF;
        do_start();
        send_byte(8'hF4);
        chk("R6 header ack", ack_req, 1);
        chk("R6 header not yet addressed", addressed, 0);
        pulse_bit(1'b0);
        chk("R6 header ack released", ack_req, 0);
        send_byte(8'hC5);
        chk("R6 low ack", ack_req, 1);
        chk("R6 addressed", addressed, 1);
        chk("R6 rx_addr", rx_addr, 10'h2C5);
        chk("R6 addr_is_10", addr_is_10, 1);
        chk("R6 rw_bit", rw_bit, 0);
        pulse_bit(1'b0);
        do_start();
        chk("R8 repeated start clears", addressed, 0);
        send_byte(8'hF5);
        chk("R7 read reselect ack", ack_req, 1);
        chk("R7 read reselect addressed", addressed, 1);
        chk("R7 rw_bit", rw_bit, 1);
        chk("R7 rx_addr kept", rx_addr, 10'h2C5);
        chk("R7 addr_is_10", addr_is_10, 1);
        pulse_bit(1'b1);
        do_stop();
        do_start();
        send_byte(8'hF5);
        chk("R8 read after stop ignored", ack_req, 0);
        chk("R8 read after stop not addressed", addressed, 0);
        do_stop();
    endtask

    task automatic t_10bit_mismatch();
        mode10 = 1; own_addr10 = 10'h2C5; mask10 = 10'h3FF;
        do_start();
        send_byte(8'hF4); pulse_bit(1'b0);
        send_byte(8'hC4);
        chk("R6 low mismatch ack", ack_req, 0);
        chk("R6 low mismatch addressed", addressed, 0);
        pulse_bit(1'b1);
        do_start();
        send_byte(8'hF5);
        chk("R7 read without write match", ack_req, 0);
        do_start();
        send_byte(8'hF2);
        chk("R6 wrong A9:A8", ack_req, 0);
        do_start();
        send_byte(8'hE4);
        chk("R6 wrong prefix", ack_req, 0);
        do_stop();
        mask10 = 10'h0F0;
        do_start();
        send_byte(8'hF0); pulse_bit(1'b0);
        send_byte(8'hC0);
        chk("R6 masked 10-bit addressed", addressed, 1);
        chk("R6 masked 10-bit rx_addr", rx_addr, 10'h0C0);
        pulse_bit(1'b0);
        do_stop();
    endtask

    task automatic t_mode_select();
        mode10 = 1; own_addr7 = 7'h5A; mask7 = 7'h7F;
        own_addr10 = 10'h2C5; mask10 = 10'h3FF;
        do_start();
        send_byte({7'h5A, 1'b0});
        chk("R9 7-bit byte in 10-bit mode", ack_req, 0);
        do_stop();
        mode10 = 0; own_addr7 = 7'h7A;
        do_start();
        send_byte(8'hF4);
        chk("R9 11110 byte in 7-bit mode", addressed, 1);
        chk("R9 length is 7-bit", addr_is_10, 0);
        chk("R9 rx_addr", rx_addr, 10'h07A);
        pulse_bit(1'b0);
        do_stop();
    endtask

    task automatic t_start_midbyte();
        mode10 = 0; own_addr7 = 7'h5A; mask7 = 7'h7F;
        do_start();
        pulse_bit(1'b1); pulse_bit(1'b1); pulse_bit(1'b0);
        do_start();
        send_byte({7'h5A, 1'b0});
        chk("R8 restart mid-byte then match", addressed, 1);
        chk("R8 restart mid-byte rx", rx_addr, 10'h05A);
        pulse_bit(1'b0);
        do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_7bit_exact();
        t_7bit_masked();
        t_promisc();
        t_10bit_write_read();
        t_10bit_mismatch();
        t_mode_select();
        t_start_midbyte();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule